// File: doc/BRIEF.md
# Lane-Masked Word Data Memory

This block is a single-port data store of 1024 entries, each one a 32-bit word. One 10-bit word address serves both the read path and the write path. A write is committed on the falling clock edge. A 4-bit lane mask decides which bytes of the word take the new data. Lanes whose mask bit is clear keep the value they already hold.

The read path has no register. The output always shows the full word at the address that is currently applied. A word written on a falling edge is therefore already visible at the output before the following rising edge. The storage is split into one byte-wide bank per lane. An active-low asynchronous reset clears every word to zero, which gives simulation a known starting state.

Top module: `dmem_word_ram`

## Requirements
- R1: While rst_ni is low, and after it rises, every word reads as 0x00000000 until it is written. Asserting rst_ni again at any time clears all words.
- R2: The memory holds 1024 distinct 32-bit words, selected by the 10-bit addr_i. Address 0 and address 1023 are both usable, and a write to one address never changes another address.
- R3: With we_i = 1, the write takes effect on the falling edge of clk_i. Before that edge the output shows the old word, and after it the output shows the new word, before the next rising edge.
- R4: Mask bit be_i[k] selects data bits 8k+7 down to 8k. Those bits of wdata_i are stored when we_i = 1, and be_i = 4'b1111 stores the whole word.
- R5: During a write, each byte whose be_i bit is 0 keeps its previous value. This includes be_i = 4'b0000, which leaves the word unchanged.
- R6: With we_i = 0, wdata_i and be_i have no effect and no word changes.
- R7: rdata_o is combinational from addr_i. A new address shows its stored word within the same cycle.
- R8: The one address input selects the word that is written and the word that is read. A write can be read back by applying the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes commit on its falling edge |
| rst_ni | input | 1 | Active-low asynchronous clear of all words |
| addr_i | input | 10 | Word address shared by read and write |
| wdata_i | input | 32 | Write data, four byte lanes |
| we_i | input | 1 | Write enable |
| be_i | input | 4 | Byte-lane mask; bit k covers data bits 8k+7:8k |
| rdata_o | output | 32 | Word stored at addr_i |

## Verification
The hardest behaviour to reach from the ports is the half-cycle window around the falling edge. The old word must still be on the output before that edge, and the merged word must be there after it, both within one clock cycle. The bench sets each operation just after the rising edge. Its scoreboard then compares the output twice per cycle: once before the falling edge, against the model's old word, and once after it, against the merged word. Sequences of single-lane writes and mixed-lane writes to one address build up a word byte by byte. This shows that unmasked lanes survive several writes in a row.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int unsigned ADDR_W_DEF = 10;
  localparam int unsigned LANE_W_DEF = 8;
  localparam int unsigned LANES_DEF  = 4;
endpackage

// File: rtl/dmem_wr_decode.sv
module dmem_wr_decode #(
  parameter int unsigned LANES = dmem_pkg::LANES_DEF
) (
  input  logic             we_i,
  input  logic [LANES-1:0] be_i,
  output logic [LANES-1:0] lane_we_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_we_o[k] = we_i & be_i[k];
  end
endmodule

// File: rtl/dmem_byte_bank.sv
module dmem_byte_bank #(
  parameter int unsigned ADDR_W = dmem_pkg::ADDR_W_DEF,
  parameter int unsigned LANE_W = dmem_pkg::LANE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem_q [DEPTH];

  // falling-edge commit
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/dmem_word_ram.sv
module dmem_word_ram #(
  parameter int unsigned ADDR_W = dmem_pkg::ADDR_W_DEF,
  parameter int unsigned LANE_W = dmem_pkg::LANE_W_DEF,
  parameter int unsigned LANES  = dmem_pkg::LANES_DEF,
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  be_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [LANES-1:0] lane_we;

  dmem_wr_decode #(.LANES(LANES)) u_dec (
    .we_i     (we_i),
    .be_i     (be_i),
    .lane_we_o(lane_we)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_bank
    dmem_byte_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .addr_i (addr_i),
      .we_i   (lane_we[k]),
      .wdata_i(wdata_i[k*LANE_W +: LANE_W]),
      .rdata_o(rdata_o[k*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/dmem_word_ram_chk.sv
module dmem_word_ram_chk #(
  parameter int unsigned ADDR_W = dmem_pkg::ADDR_W_DEF,
  parameter int unsigned LANE_W = dmem_pkg::LANE_W_DEF,
  parameter int unsigned LANES  = dmem_pkg::LANES_DEF,
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic [LANES-1:0]  be_i,
  input logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] be_mask;
  always_comb begin
    for (int k = 0; k < LANES; k++) be_mask[k*LANE_W +: LANE_W] = {LANE_W{be_i[k]}};
  end

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RST_CLEAR: assert (rdata_o == '0); // R1
  end

  AST_LANE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> ((rdata_o ^ wdata_i) & be_mask) == '0); // R4

  AST_LANE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && $stable(addr_i) |-> ((rdata_o ^ $past(rdata_o)) & ~be_mask) == '0); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i && $stable(addr_i) |-> $stable(rdata_o)); // R6
endmodule

bind dmem_word_ram dmem_word_ram_chk #(
  .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)
) u_chk (.*);

// File: tb/dmem_word_ram_tb.sv
module dmem_word_ram_tb;
  localparam int unsigned PERIOD = 10;
  localparam int unsigned DEPTH  = 1024;

  typedef struct {
    logic [31:0] pre;
    logic [31:0] post;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] rdata;

  logic [31:0] model [DEPTH];
  item_t       sb_q [$];
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dmem_word_ram u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .addr_i (addr),
    .wdata_i(wdata),
    .we_i   (we),
    .be_i   (be),
    .rdata_o(rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
  endtask

  // driver: one operation per cycle, pushed to scoreboard
  task automatic op(input logic w, input logic [9:0] a, input logic [31:0] d,
                    input logic [3:0] m, input string tag);
    item_t it;
    @(posedge clk); #1;
    we = w; addr = a; wdata = d; be = m;
    it.pre = model[a];
    if (w && rst_n) begin
      for (int k = 0; k < 4; k++) if (m[k]) model[a][k*8 +: 8] = d[k*8 +: 8];
    end
    it.post = model[a];
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  task automatic rd(input logic [9:0] a, input string tag);
    op(1'b0, a, 32'hFFFF_FFFF, 4'hF, tag);
  endtask

  // monitor: before the falling edge old word, after it merged word
  initial begin
    item_t it;
    forever begin
      @(posedge clk); #3;
      if (sb_q.size() > 0) begin
        it = sb_q[0];
        check({it.tag, " pre-edge"}, rdata, it.pre);
        @(negedge clk); #3;
        check({it.tag, " post-edge"}, rdata, it.post);
        void'(sb_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    model_clear();
    // R1: held in reset
    rd(10'd0, "R1 in reset");
    rd(10'd1023, "R1 in reset");
    @(posedge clk); #1; rst_n = 1'b1;
    rd(10'd0, "R1");
    rd(10'd1023, "R1");
    rd(10'd300, "R1");
    // R3/R4 full-word writes, R2 at both ends
    op(1'b1, 10'd0, 32'hA5A5_1234, 4'hF, "R3 R4 full");
    op(1'b1, 10'd1023, 32'hDEAD_BEEF, 4'hF, "R2 top");
    rd(10'd0, "R2 R8");
    rd(10'd1023, "R2 R8");
    // R4/R5 lane building at address 1
    op(1'b1, 10'd1, 32'h1122_3344, 4'b0001, "R4 lane0");
    op(1'b1, 10'd1, 32'hAABB_CCDD, 4'b0100, "R5 lane2");
    op(1'b1, 10'd1, 32'h7766_5544, 4'b1000, "R4 lane3");
    op(1'b1, 10'd1, 32'hFFFF_FFFF, 4'b0000, "R5 none");
    op(1'b1, 10'd1023, 32'h0123_4567, 4'b0110, "R5 mid lanes");
    op(1'b1, 10'd0, 32'h0F0F_F0F0, 4'b1001, "R4 R5 outer");
    // R6 disabled write ignored
    op(1'b0, 10'd1, 32'h0000_0000, 4'hF, "R6");
    op(1'b0, 10'd1023, 32'h5555_5555, 4'b1010, "R6");
    rd(10'd1, "R6 readback");
    // R7 address changes every cycle
    rd(10'd0, "R7");
    rd(10'd1, "R7");
    rd(10'd1023, "R7");
    rd(10'd2, "R7");
    // R2 no aliasing across a block
    for (int i = 2; i < 10; i++) op(1'b1, 10'(i), 32'hC000_0000 + 32'(i * 17), 4'hF, "R2 fill");
    for (int i = 2; i < 10; i++) rd(10'(i), "R2 R8 block");
    rd(10'd512, "R2 untouched");
    // R1 reset in mid-run
    @(posedge clk); #1; rst_n = 1'b0; model_clear();
    rd(10'd1, "R1 re-reset");
    @(posedge clk); #1; rst_n = 1'b1;
    rd(10'd0, "R1 after re-reset");
    rd(10'd1023, "R1 after re-reset");
    rd(10'd5, "R1 after re-reset");
    while (sb_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule